// File: doc/BRIEF.md
# Aperture address remapping table

The block remaps a fixed, page-aligned bus-address window onto physical memory, one 4 KiB page at a time. It holds one 32-bit entry per page of the window. Each entry carries a valid flag in bit 31 and a physical page frame in bits 30..12. An incoming address inside the window has its page looked up in the table. The low twelve address bits pass straight through to the physical address.

Software never addresses the table directly. It first loads a window address into an entry-address register, which selects one entry. It then writes or reads an entry-data register to store or fetch that entry's word. A configuration register holds a single global enable. While the enable is clear, every access inside the window faults. Reading the configuration register has no side effect, so software can use that read as a completion barrier.

The translation port is registered. A request presented on one clock edge has its response one cycle later. The response is exactly one of three outcomes: a physical address, a fault, or an out-of-range flag.

Top module: `aperture_remap_table`

## Requirements
- R1: After reset the enable bit is 0, the entry-address register is 0, every table entry reads 0, and no response flag is raised.
- R2: A write to register offset 0x4 loads the full 32-bit entry-address register. A read of offset 0x4 returns that value, and the value holds until the register is written again.
- R3: While the entry-address register holds an address inside the window, a write to offset 0x8 stores the 32-bit word into entry (addr - base) >> 12. A read of offset 0x8 returns that entry's stored word. Repeated data accesses hit the same entry.
- R4: While the entry-address register holds an address outside the window, a write to offset 0x8 changes no entry, and a read of offset 0x8 returns 0.
- R5: A write to offset 0x0 sets the enable to bit 0 of the written word. A read of offset 0x0 returns {31'b0, enable} and changes no state.
- R6: The enable is 1, the address lies inside the window, and the entry has bit 31 set. One cycle after the request, rsp_valid_o is 1 and rsp_paddr_o = {1'b0, entry[30:12], addr[11:0]}. rsp_fault_o and rsp_oor_o are both 0.
- R7: The enable is 1, the address lies inside the window, and the entry has bit 31 clear. One cycle later rsp_fault_o is 1 and rsp_paddr_o is 0.
- R8: With the enable at 0, every request inside the window responds with rsp_fault_o = 1 and rsp_paddr_o = 0, whatever the entry holds.
- R9: A request below base or at or above base + PAGE_COUNT*4096 responds with rsp_oor_o = 1, rsp_fault_o = 0 and rsp_paddr_o = 0. The address end - 1 is inside the window.
- R10: A read of any offset other than 0x0, 0x4 or 0x8 returns 0. A write to such an offset changes no register and no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_req_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_off_i | input | 4 | Byte offset inside the register block |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid in the same cycle as the strobe |
| xl_valid_i | input | 1 | Translation request |
| xl_addr_i | input | 32 | Bus address to translate |
| rsp_valid_o | output | 1 | Response for the request of the previous cycle |
| rsp_paddr_o | output | 32 | Translated physical address, 0 unless translated |
| rsp_fault_o | output | 1 | Inside the window but disabled or entry invalid |
| rsp_oor_o | output | 1 | Address outside the window |

## Verification
The bench probes the window edges at base - 1, base, end - 1 and end. A design with an off-by-one window compare would return a fault or a bogus frame where an out-of-range flag is due. It loads the entry address with exactly the end address, whose page index truncates to entry 0, and then writes data. A design that skips the window check on the selected entry would corrupt entry 0, and the bench catches that on a later readback. It clears the enable while entries stay valid, to catch translation that ignores the enable, and it writes to an undecoded offset, to catch a decoder that aliases onto a real register. Random traffic mixes writes and reads across all three registers with translations carrying random page offsets. A wrong entry index or a dropped pass-through bit then shows up as an address miscompare.

// File: rtl/aprt_pkg.sv
package aprt_pkg;
  localparam int unsigned PAGE_SHIFT = 12;

  typedef enum logic [3:0] {
    OFF_CFG   = 4'h0,
    OFF_EADDR = 4'h4,
    OFF_EDATA = 4'h8
  } reg_off_e;

  function automatic logic in_window(logic [31:0] a, logic [31:0] base,
                                     logic [32:0] span);
    logic [32:0] lim;
    lim = {1'b0, base} + span;
    return (a >= base) && ({1'b0, a} < lim);
  endfunction

  function automatic logic [31:0] page_of(logic [31:0] a, logic [31:0] base);
    return (a - base) >> PAGE_SHIFT;
  endfunction
endpackage

// File: rtl/aprt_regs.sv
module aprt_regs
  import aprt_pkg::*;
#(
  parameter logic [31:0] BASE       = 32'h4000_0000,
  parameter int unsigned PAGE_COUNT = 64,
  localparam int unsigned IDX_W     = $clog2(PAGE_COUNT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [3:0]       off_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o,
  output logic             en_o,
  output logic [IDX_W-1:0] sel_idx_o,
  output logic             ent_we_o,
  input  logic [31:0]      ent_rdata_i
);
  localparam logic [32:0] SPAN = 33'(PAGE_COUNT) << PAGE_SHIFT;

  logic [31:0] eaddr_q;
  logic        sel_hit;
  logic        wr_cfg, wr_eaddr, wr_edata;

  assign sel_hit   = in_window(eaddr_q, BASE, SPAN);
  assign sel_idx_o = IDX_W'(page_of(eaddr_q, BASE));

  assign wr_cfg   = req_i && we_i && (off_i == OFF_CFG);
  assign wr_eaddr = req_i && we_i && (off_i == OFF_EADDR);
  assign wr_edata = req_i && we_i && (off_i == OFF_EDATA);
  assign ent_we_o = wr_edata && sel_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o    <= 1'b0;
      eaddr_q <= '0;
    end else begin
      if (wr_cfg)   en_o    <= wdata_i[0];
      if (wr_eaddr) eaddr_q <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i) begin
      case (off_i)
        OFF_CFG:   rdata_o = {31'b0, en_o};
        OFF_EADDR: rdata_o = eaddr_q;
        OFF_EDATA: rdata_o = sel_hit ? ent_rdata_i : 32'h0;
        default:   rdata_o = '0;
      endcase
    end
  end

  AST_CFG_READ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> $stable(en_o)); // R5
  AST_EADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i && off_i == 4'h4) |=> $stable(eaddr_q)); // R2
  AST_OOW_DATA_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && off_i == 4'h8 && !sel_hit) |-> rdata_o == 32'h0); // R4
endmodule

// File: rtl/aprt_store.sv
module aprt_store #(
  parameter int unsigned PAGE_COUNT = 64,
  localparam int unsigned IDX_W     = $clog2(PAGE_COUNT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      a_rdata_o,
  input  logic [IDX_W-1:0] b_idx_i,
  output logic             b_vld_o,
  output logic [18:0]      b_frame_o
);
  logic [31:0] ent_q [PAGE_COUNT];

  for (genvar g = 0; g < PAGE_COUNT; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 ent_q[g] <= '0;
      else if (we_i && wr_idx_i == IDX_W'(g))      ent_q[g] <= wdata_i;
    end
  end

  // Index beyond a non-power-of-two count reads as an empty entry.
  always_comb begin
    a_rdata_o = '0;
    if (32'(wr_idx_i) < PAGE_COUNT) a_rdata_o = ent_q[wr_idx_i];
  end

  always_comb begin
    b_vld_o   = 1'b0;
    b_frame_o = '0;
    if (32'(b_idx_i) < PAGE_COUNT) begin
      b_vld_o   = ent_q[b_idx_i][31];
      b_frame_o = ent_q[b_idx_i][30:12];
    end
  end
endmodule

// File: rtl/aprt_lookup.sv
module aprt_lookup
  import aprt_pkg::*;
#(
  parameter logic [31:0] BASE       = 32'h4000_0000,
  parameter int unsigned PAGE_COUNT = 64,
  localparam int unsigned IDX_W     = $clog2(PAGE_COUNT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             xl_valid_i,
  input  logic [31:0]      xl_addr_i,
  output logic [IDX_W-1:0] idx_o,
  input  logic             ent_vld_i,
  input  logic [18:0]      ent_frame_i,
  output logic             rsp_valid_o,
  output logic [31:0]      rsp_paddr_o,
  output logic             rsp_fault_o,
  output logic             rsp_oor_o
);
  localparam logic [32:0] SPAN = 33'(PAGE_COUNT) << PAGE_SHIFT;

  logic hit, ok;

  assign hit   = in_window(xl_addr_i, BASE, SPAN);
  assign idx_o = IDX_W'(page_of(xl_addr_i, BASE));
  assign ok    = hit && en_i && ent_vld_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_paddr_o <= '0;
      rsp_fault_o <= 1'b0;
      rsp_oor_o   <= 1'b0;
    end else begin
      rsp_valid_o <= xl_valid_i;
      rsp_paddr_o <= (xl_valid_i && ok) ? {1'b0, ent_frame_i, xl_addr_i[11:0]} : 32'h0;
      rsp_fault_o <= xl_valid_i && hit && !ok;
      rsp_oor_o   <= xl_valid_i && !hit;
    end
  end

  AST_ONE_OUTCOME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rsp_fault_o, rsp_oor_o})); // R9
  AST_FLAG_NEEDS_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_fault_o || rsp_oor_o) |-> rsp_valid_o); // R7
  AST_DISABLED_FAULTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xl_valid_i && !en_i) |=> (rsp_fault_o || rsp_oor_o)); // R8
  AST_OFFSET_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_fault_o && !rsp_oor_o) |->
      (rsp_paddr_o[11:0] == $past(xl_addr_i[11:0]) && !rsp_paddr_o[31])); // R6
  AST_FLAG_ZERO_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_fault_o || rsp_oor_o) |-> rsp_paddr_o == 32'h0); // R9
endmodule

// File: rtl/aperture_remap_table.sv
module aperture_remap_table #(
  parameter logic [31:0] BASE       = 32'h4000_0000,
  parameter int unsigned PAGE_COUNT = 64
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_req_i,
  input  logic        reg_we_i,
  input  logic [3:0]  reg_off_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  input  logic        xl_valid_i,
  input  logic [31:0] xl_addr_i,
  output logic        rsp_valid_o,
  output logic [31:0] rsp_paddr_o,
  output logic        rsp_fault_o,
  output logic        rsp_oor_o
);
  localparam int unsigned IDX_W = $clog2(PAGE_COUNT);

  logic             en;
  logic [IDX_W-1:0] sel_idx, lk_idx;
  logic             ent_we;
  logic [31:0]      ent_rdata;
  logic             lk_vld;
  logic [18:0]      lk_frame;

  aprt_regs #(.BASE(BASE), .PAGE_COUNT(PAGE_COUNT)) u_regs (
    .clk_i, .rst_ni,
    .req_i(reg_req_i), .we_i(reg_we_i), .off_i(reg_off_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .en_o(en), .sel_idx_o(sel_idx), .ent_we_o(ent_we),
    .ent_rdata_i(ent_rdata)
  );

  aprt_store #(.PAGE_COUNT(PAGE_COUNT)) u_store (
    .clk_i, .rst_ni,
    .we_i(ent_we), .wr_idx_i(sel_idx), .wdata_i(reg_wdata_i),
    .a_rdata_o(ent_rdata),
    .b_idx_i(lk_idx), .b_vld_o(lk_vld), .b_frame_o(lk_frame)
  );

  aprt_lookup #(.BASE(BASE), .PAGE_COUNT(PAGE_COUNT)) u_lookup (
    .clk_i, .rst_ni, .en_i(en),
    .xl_valid_i, .xl_addr_i, .idx_o(lk_idx),
    .ent_vld_i(lk_vld), .ent_frame_i(lk_frame),
    .rsp_valid_o, .rsp_paddr_o, .rsp_fault_o, .rsp_oor_o
  );
endmodule

// File: tb/aperture_remap_table_bench.sv
`timescale 1ns/1ps
module aperture_remap_table_bench;
  localparam logic [31:0] BASE = 32'h4000_0000;
  localparam int unsigned PAGES = 64;
  localparam logic [31:0] WEND = BASE + PAGES * 4096;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 0, we = 0;
  logic [3:0]  off = 0;
  logic [31:0] wdata = 0, rdata;
  logic        xv = 0;
  logic [31:0] xa = 0;
  logic        rv, flt, oor;
  logic [31:0] pa;

  int checks = 0, fails = 0;
  logic [31:0] m_ent [PAGES];
  logic        m_en;
  logic [31:0] m_ea;

  always #4 clk = ~clk;

  aperture_remap_table #(.BASE(BASE), .PAGE_COUNT(PAGES)) u_aperture_remap_table (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_req_i(req), .reg_we_i(we), .reg_off_i(off),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .xl_valid_i(xv), .xl_addr_i(xa),
    .rsp_valid_o(rv), .rsp_paddr_o(pa), .rsp_fault_o(flt), .rsp_oor_o(oor)
  );

  function automatic logic inwin(logic [31:0] a);
    return (a >= BASE) && (a < WEND);
  endfunction

  function automatic int pidx(logic [31:0] a);
    return int'((a - BASE) >> 12);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(logic [3:0] o, logic [31:0] d);
    @(negedge clk);
    req = 1; we = 1; off = o; wdata = d;
    @(posedge clk); #1;
    req = 0; we = 0;
    if (o == 4'h0) m_en = d[0];
    else if (o == 4'h4) m_ea = d;
    else if (o == 4'h8 && inwin(m_ea)) m_ent[pidx(m_ea)] = d;
  endtask

  task automatic reg_rd(logic [3:0] o, output logic [31:0] d);
    @(negedge clk);
    req = 1; we = 0; off = o;
    #1 d = rdata;
    @(posedge clk); #1;
    req = 0;
  endtask

  function automatic logic [31:0] exp_rd(logic [3:0] o);
    case (o)
      4'h0: return {31'b0, m_en};
      4'h4: return m_ea;
      4'h8: return inwin(m_ea) ? m_ent[pidx(m_ea)] : 32'h0;
      default: return 32'h0;
    endcase
  endfunction

  task automatic rd_chk(string tag, logic [3:0] o);
    logic [31:0] d;
    reg_rd(o, d);
    chk(tag, d, exp_rd(o));
  endtask

  task automatic xl_chk(logic [31:0] a);
    logic [31:0] e_pa;
    logic e_f, e_o;
    string tag;
    e_o = !inwin(a);
    e_f = 0; e_pa = 0;
    if (e_o) tag = "R9";
    else if (!m_en) begin e_f = 1; tag = "R8"; end
    else if (!m_ent[pidx(a)][31]) begin e_f = 1; tag = "R7"; end
    else begin e_pa = {1'b0, m_ent[pidx(a)][30:12], a[11:0]}; tag = "R6"; end
    @(negedge clk);
    xv = 1; xa = a;
    @(posedge clk); #1;
    xv = 0;
    @(negedge clk);
    chk({tag, " flags"}, {29'b0, rv, flt, oor}, {29'b0, 1'b1, e_f, e_o});
    chk({tag, " paddr"}, pa, e_pa);
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20417));
    for (int i = 0; i < PAGES; i++) m_ent[i] = 0;
    m_en = 0; m_ea = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rsp flags", {29'b0, rv, flt, oor}, 32'h0);
    rd_chk("R1 cfg", 4'h0);
    rd_chk("R1 eaddr", 4'h4);
    for (int i = 0; i < PAGES; i++) begin
      reg_wr(4'h4, BASE + i * 4096);
      rd_chk("R1 entry", 4'h8);
    end
    xl_chk(BASE);
    // R2 / R3 directed
    reg_wr(4'h4, BASE + 5 * 4096 + 32'h123);
    rd_chk("R2 eaddr", 4'h4);
    reg_wr(4'h8, 32'h8001_2000);
    rd_chk("R3 read", 4'h8);
    reg_wr(4'h8, 32'h8005_6000);
    rd_chk("R3 same entry", 4'h8);
    rd_chk("R2 hold", 4'h4);
    reg_wr(4'h4, BASE);
    reg_wr(4'h8, 32'h8000_A000);
    reg_wr(4'h4, BASE + (PAGES - 1) * 4096);
    reg_wr(4'h8, 32'hFFFF_F000);
    // R4 out-of-window select: end address would alias entry 0
    reg_wr(4'h4, WEND);
    reg_wr(4'h8, 32'h8777_7000);
    rd_chk("R4 read zero", 4'h8);
    reg_wr(4'h4, BASE - 1);
    reg_wr(4'h8, 32'h8666_6000);
    rd_chk("R4 read zero low", 4'h8);
    reg_wr(4'h4, BASE);
    rd_chk("R4 entry0 untouched", 4'h8);
    reg_wr(4'h4, BASE + (PAGES - 1) * 4096);
    rd_chk("R4 last untouched", 4'h8);
    // R10 undecoded offset
    reg_wr(4'hC, 32'hFFFF_FFFF);
    rd_chk("R10 undecoded read", 4'hC);
    rd_chk("R10 cfg", 4'h0);
    rd_chk("R10 eaddr", 4'h4);
    rd_chk("R10 entry", 4'h8);
    // R5 enable and barrier read
    reg_wr(4'h0, 32'hFFFF_FFFF);
    rd_chk("R5 cfg set", 4'h0);
    rd_chk("R5 cfg reread", 4'h0);
    // R6 / R7 / R9 boundaries
    xl_chk(BASE + 32'hABC);
    xl_chk(WEND - 1);
    xl_chk(WEND);
    xl_chk(BASE - 1);
    xl_chk(BASE + 7 * 4096 + 32'h10);
    xl_chk(32'h0);
    // R8 disable
    reg_wr(4'h0, 32'h0000_0002);
    rd_chk("R5 cfg clear", 4'h0);
    xl_chk(BASE + 32'h44);
    xl_chk(WEND - 1);
    xl_chk(WEND);
    reg_wr(4'h0, 32'h1);
    // random traffic
    for (int n = 0; n < 1500; n++) begin
      int k;
      logic [31:0] a;
      k = int'($urandom_range(0, 9));
      if ($urandom_range(0, 7) == 0)
        a = ($urandom_range(0, 1) == 1) ? WEND + $urandom_range(0, 8191) : BASE - 1 - $urandom_range(0, 8191);
      else
        a = BASE + $urandom_range(0, PAGES * 4096 - 1);
      case (k)
        0, 1: reg_wr(4'h4, a);
        2, 3: reg_wr(4'h8, {$urandom_range(0, 1) == 1, 31'($urandom)});
        4: rd_chk("R3 rand data", 4'h8);
        5: if ($urandom_range(0, 3) == 0) reg_wr(4'h0, 32'($urandom_range(0, 1)));
           else rd_chk("R5 rand cfg", 4'h0);
        6: rd_chk("R2 rand eaddr", 4'h4);
        default: xl_chk(a);
      endcase
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule